// File: doc/BRIEF.md
# Serial Port Register Front End with Prioritised Interrupt

This block is the software-visible side of a 16550-style serial port. It decodes 32-bit word accesses from a memory-mapped bus into eight word-aligned registers. It holds the configuration written by software: the interrupt enables, the line-control byte, the modem-control bits and the baud divisor. It keeps the line-status and modem-status bits and latches the most recently received byte.

Bytes written to the data register are handed to a separate transmit engine through a one-cycle strobe. Bytes from the receive engine arrive on a one-cycle strobe together with their error flags. Modem pin changes arrive as delta strobes beside the live levels.

From this state the block drives a single interrupt line and a 3-bit identification code. The code is chosen by fixed priority: receive errors first, then received data, then transmit holding empty, then modem changes. Reads of the data, line-status and modem-status registers acknowledge their causes, and the interrupt follows in the cycle after the read.

Top module: `uart_regfile`

## Requirements
- R1: After reset, line status reads 0x60 (bit5 holding empty, bit6 transmitter empty). The identification register reads 0x1 and `irq` is low. Modem status, received data and all configuration outputs are zero.
- R2: Register offset = byte address bits 4:2, in this order: 0 data, 1 enable, 2 identification, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 divisor. An access takes effect only when `bus_be` is 4'hF, address bits 1:0 are zero and all address bits above bit 4 are zero. Any other address reads zero.
- R3: Enable (offset 1, bits 3:0), line control (offset 3, 8 bits), modem control (offset 4, bits 1:0) and divisor (offset 7, `DIV_W` bits) hold the written value until the next write to them. They read back as zero. Line control, modem control and the divisor appear on `line_ctrl`, `modem_ctrl` and `divisor`.
- R4: Writes to identification, line status and modem status change nothing.
- R5: A read of offset 0 returns the latched byte in bits 7:0 and clears data ready (line status bit0).
- R6: A received byte that arrives while data ready is set, without a data read in the same cycle, sets overrun (bit1). It replaces the latched byte, and data ready stays set.
- R7: The receive strobe ORs `rx_perr`, `rx_ferr` and `rx_brk` into line status bits 2, 3 and 4. A read of line status returns the bits and then clears bits 1 to 4.
- R8: Modem status bits 3:0 accumulate `modem_delta` and are cleared by a read of modem status. Bits 7:4 show `modem_lvl` live.
- R9: An accepted write to offset 0 while holding empty is set pulses `tx_valid` for one cycle with `tx_data` = write data bits 7:0. The write clears line status bits 5 and 6. `tx_taken` sets bit5 again, and `tx_done` sets bit6 again.
- R10: A write to offset 0 while holding empty is clear is dropped: no `tx_valid` pulse.
- R11: The identification value is chosen by priority:
  - 3'b110 when any of line status bits 1 to 4 is set and enable bit2 is set;
  - else 3'b100 when data ready is set and enable bit0 is set;
  - else 3'b010 when holding empty is set and enable bit1 is set;
  - else 3'b000 when any modem delta bit is set and enable bit3 is set;
  - else 3'b001.
- R12: `irq` is high exactly when the identification value is not 3'b001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| tx_valid | output | 1 | One-cycle byte hand-off to transmitter |
| tx_data | output | 8 | Byte for transmitter |
| tx_taken | input | 1 | Transmitter has taken the held byte |
| tx_done | input | 1 | Transmitter finished shifting |
| rx_strobe | input | 1 | Received byte valid (one cycle) |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error with this byte |
| rx_ferr | input | 1 | Framing error with this byte |
| rx_brk | input | 1 | Break seen with this byte |
| modem_lvl | input | 4 | Live CTS, DSR, RI, DCD (bit0..bit3) |
| modem_delta | input | 4 | Change strobes for the same four lines |
| line_ctrl | output | 8 | Line-control value for serial engine |
| modem_ctrl | output | 2 | Modem-control bits |
| divisor | output | DIV_W | Baud divisor |
| irq | output | 1 | Interrupt request |

## Verification
The interrupt logic is tried with one cause at a time and then with several causes present together. Transmit-only enabling, receive plus transmit, overrun with line-status enabling, and modem-only enabling each show whether the priority picks the right winner and whether each acknowledge read releases only its own cause. Receive patterns are separated into a single byte, two bytes without an intervening read (overrun) and a byte carrying all three error flags. Bus patterns cover write-only, read-only and unmapped offsets, plus a partial-byte write, so decode faults show up on the outputs.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
    localparam int NUM_REGS = 8;

    typedef enum logic [2:0] {
        OFF_DATA = 3'd0,
        OFF_IEN  = 3'd1,
        OFF_IID  = 3'd2,
        OFF_LCTL = 3'd3,
        OFF_MCTL = 3'd4,
        OFF_LSTA = 3'd5,
        OFF_MSTA = 3'd6,
        OFF_DIVR = 3'd7
    } reg_off_e;

    localparam logic [2:0] IID_LINE = 3'b110;
    localparam logic [2:0] IID_RXD  = 3'b100;
    localparam logic [2:0] IID_THE  = 3'b010;
    localparam logic [2:0] IID_MDM  = 3'b000;
    localparam logic [2:0] IID_NONE = 3'b001;

    localparam int EN_RXD  = 0;
    localparam int EN_THE  = 1;
    localparam int EN_LINE = 2;
    localparam int EN_MDM  = 3;
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
    import uart_rf_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    output logic [NUM_REGS-1:0] wr_hit,
    output logic [NUM_REGS-1:0] rd_hit
);
    localparam int OFF_LSB = 2;
    localparam int OFF_W   = $clog2(NUM_REGS);
    localparam int HI_LSB  = OFF_LSB + OFF_W;

    logic [OFF_W-1:0] off;
    logic             ok;

    assign off = addr[HI_LSB-1:OFF_LSB];
    assign ok  = sel && (be == 4'hF) && (addr[OFF_LSB-1:0] == '0)
                 && (addr[ADDR_W-1:HI_LSB] == '0);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
        assign wr_hit[i] = ok &&  we && (off == OFF_W'(i));
        assign rd_hit[i] = ok && !we && (off == OFF_W'(i));
    end
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
    import uart_rf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] line_err,
    input  logic       data_rdy,
    input  logic       hold_empty,
    input  logic [3:0] mdm_delta,
    input  logic [3:0] enables,
    output logic [2:0] iid,
    output logic       irq
);
    always_comb begin
        if ((|line_err) && enables[EN_LINE])      iid = IID_LINE;
        else if (data_rdy && enables[EN_RXD])     iid = IID_RXD;
        else if (hold_empty && enables[EN_THE])   iid = IID_THE;
        else if ((|mdm_delta) && enables[EN_MDM]) iid = IID_MDM;
        else                                      iid = IID_NONE;
        irq = (iid != IID_NONE);
    end

    AST_ERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((|line_err) && enables[EN_LINE]) |-> (irq && iid == IID_LINE)); // R11
    AST_NO_CAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (enables == 4'd0) |-> !irq); // R12
endmodule

// File: rtl/uart_rf_rdmux.sv
module uart_rf_rdmux
    import uart_rf_pkg::*;
(
    input  logic [NUM_REGS-1:0] rd_hit,
    input  logic [7:0]          rx_buf,
    input  logic [2:0]          iid,
    input  logic [7:0]          lsr,
    input  logic [7:0]          msr,
    output logic [31:0]         rdata
);
    logic [31:0] word [NUM_REGS];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) word[i] = '0;
        word[OFF_DATA] = {24'd0, rx_buf};
        word[OFF_IID]  = {29'd0, iid};
        word[OFF_LSTA] = {24'd0, lsr};
        word[OFF_MSTA] = {24'd0, msr};
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_hit[i]) rdata = rdata | word[i];
        end
    end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_rf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_taken,
    input  logic              tx_done,
    input  logic              rx_strobe,
    input  logic [7:0]        rx_byte,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    input  logic [3:0]        modem_lvl,
    input  logic [3:0]        modem_delta,
    output logic [7:0]        line_ctrl,
    output logic [1:0]        modem_ctrl,
    output logic [DIV_W-1:0]  divisor,
    output logic              irq
);
    typedef struct packed {
        logic [7:0]       rbuf;
        logic [3:0]       ien;
        logic [7:0]       lctl;
        logic [1:0]       mctl;
        logic [DIV_W-1:0] divr;
        logic             dr;
        logic             oe;
        logic             pe;
        logic             fe;
        logic             bi;
        logic             thre;
        logic             temt;
        logic [3:0]       mdlt;
        logic             txv;
        logic [7:0]       txd;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_REGS-1:0] wr_hit, rd_hit;
    logic [2:0] iid;
    logic [7:0] lsr, msr;

    uart_rf_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel(bus_sel), .we(bus_we), .addr(bus_addr), .be(bus_be),
        .wr_hit(wr_hit), .rd_hit(rd_hit)
    );

    assign lsr = {1'b0, st_q.temt, st_q.thre, st_q.bi, st_q.fe, st_q.pe, st_q.oe, st_q.dr};
    assign msr = {modem_lvl, st_q.mdlt};

    uart_rf_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .line_err({st_q.bi, st_q.fe, st_q.pe, st_q.oe}),
        .data_rdy(st_q.dr), .hold_empty(st_q.thre),
        .mdm_delta(st_q.mdlt), .enables(st_q.ien),
        .iid(iid), .irq(irq)
    );

    uart_rf_rdmux u_mux (
        .rd_hit(rd_hit), .rx_buf(st_q.rbuf), .iid(iid),
        .lsr(lsr), .msr(msr), .rdata(bus_rdata)
    );

    always_comb begin
        st_d     = st_q;
        st_d.txv = 1'b0;
        // configuration writes
        if (wr_hit[OFF_IEN])  st_d.ien  = bus_wdata[3:0];
        if (wr_hit[OFF_LCTL]) st_d.lctl = bus_wdata[7:0];
        if (wr_hit[OFF_MCTL]) st_d.mctl = bus_wdata[1:0];
        if (wr_hit[OFF_DIVR]) st_d.divr = bus_wdata[DIV_W-1:0];
        // transmit path
        if (tx_taken) st_d.thre = 1'b1;
        if (tx_done)  st_d.temt = 1'b1;
        if (wr_hit[OFF_DATA] && st_q.thre) begin
            st_d.txv  = 1'b1;
            st_d.txd  = bus_wdata[7:0];
            st_d.thre = 1'b0;
            st_d.temt = 1'b0;
        end
        // acknowledge reads
        if (rd_hit[OFF_DATA]) st_d.dr = 1'b0;
        if (rd_hit[OFF_LSTA]) begin
            st_d.oe = 1'b0;
            st_d.pe = 1'b0;
            st_d.fe = 1'b0;
            st_d.bi = 1'b0;
        end
        if (rd_hit[OFF_MSTA]) st_d.mdlt = 4'd0;
        // receive path: new events win over same-cycle clears
        if (rx_strobe) begin
            st_d.oe   = st_d.oe | (st_q.dr && !rd_hit[OFF_DATA]);
            st_d.dr   = 1'b1;
            st_d.rbuf = rx_byte;
            st_d.pe   = st_d.pe | rx_perr;
            st_d.fe   = st_d.fe | rx_ferr;
            st_d.bi   = st_d.bi | rx_brk;
        end
        st_d.mdlt = st_d.mdlt | modem_delta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.thre <= 1'b1;
            st_q.temt <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid   = st_q.txv;
    assign tx_data    = st_q.txd;
    assign line_ctrl  = st_q.lctl;
    assign modem_ctrl = st_q.mctl;
    assign divisor    = st_q.divr;

    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> (lsr == 8'h60)); // R1
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(|wr_hit) |=> ($stable(st_q.ien) && $stable(divisor) && $stable(line_ctrl))); // R3
    AST_RO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit[OFF_LSTA] && !rx_strobe && !tx_taken && !tx_done) |=> $stable(lsr)); // R4
    AST_DR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit[OFF_DATA] && !rx_strobe) |=> !st_q.dr); // R5
    AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && st_q.dr && !rd_hit[OFF_DATA]) |=> (st_q.oe && st_q.dr)); // R6
    AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit[OFF_DATA] && st_q.thre) |=> (tx_valid && !st_q.thre)); // R9
    AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit[OFF_DATA] && !st_q.thre) |=> !tx_valid); // R10
    AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid); // R9
endmodule

// File: tb/tb_uart_regfile.sv
module tb_uart_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int DIV_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 0, bus_we = 0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [3:0] bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic tx_valid;
    logic [7:0] tx_data;
    logic tx_taken = 0, tx_done = 0;
    logic rx_strobe = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0;
    logic [7:0] rx_byte = '0;
    logic [3:0] modem_lvl = '0, modem_delta = '0;
    logic [7:0] line_ctrl;
    logic [1:0] modem_ctrl;
    logic [DIV_W-1:0] divisor;
    logic irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regfile #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) dut (.*);

    // monitor: compares each read result against the scoreboard
    always @(negedge clk) begin
        if (rst_n && bus_sel && !bus_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read: actual %h expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(posedge clk); #1;
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(posedge clk); #1;
        bus_sel = 0; bus_we = 0; bus_be = 4'hF;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        bus_sel = 1; bus_we = 0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic rx(input logic [7:0] b, input logic p, input logic f, input logic k);
        @(posedge clk); #1;
        rx_strobe = 1; rx_byte = b; rx_perr = p; rx_ferr = f; rx_brk = k;
        @(posedge clk); #1;
        rx_strobe = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(irq, 0, "R1 irq after reset");
        chk(line_ctrl, 0, "R1 line_ctrl");
        chk(divisor, 0, "R1 divisor");
        rd(8'h14, 32'h60, "R1 line status");
        rd(8'h08, 32'h1, "R1 identification");
        rd(8'h18, 32'h0, "R1 modem status");
        rd(8'h00, 32'h0, "R1 data");

        // R3 write-only configuration
        wr(8'h0C, 32'h1B);
        wr(8'h10, 32'h3);
        wr(8'h1C, 32'h1234);
        @(negedge clk);
        chk(line_ctrl, 8'h1B, "R3 line_ctrl");
        chk(modem_ctrl, 2'h3, "R3 modem_ctrl");
        chk(divisor, 16'h1234, "R3 divisor");
        rd(8'h0C, 32'h0, "R3 line control reads zero");
        rd(8'h1C, 32'h0, "R3 divisor reads zero");
        // R2 partial write ignored, unmapped reads zero
        wr(8'h1C, 32'hFFFF, 4'h3);
        @(negedge clk);
        chk(divisor, 16'h1234, "R2 partial write ignored");
        wr(8'h2C, 32'h77);
        @(negedge clk);
        chk(line_ctrl, 8'h1B, "R2 unmapped write ignored");
        rd(8'h40, 32'h0, "R2 unmapped read");

        // R4 read-only registers
        wr(8'h14, 32'h0);
        wr(8'h18, 32'hFF);
        wr(8'h08, 32'h0);
        rd(8'h14, 32'h60, "R4 line status unchanged");
        rd(8'h18, 32'h0, "R4 modem status unchanged");
        rd(8'h08, 32'h1, "R4 identification unchanged");

        // R9 transmit, R10 dropped write
        wr(8'h00, 32'hA5C3);
        @(negedge clk);
        chk(tx_valid, 1, "R9 tx_valid pulse");
        chk(tx_data, 8'hC3, "R9 tx_data low byte");
        @(negedge clk);
        chk(tx_valid, 0, "R9 pulse one cycle");
        rd(8'h14, 32'h00, "R9 holding and tx empty cleared");
        wr(8'h00, 32'h11);
        @(negedge clk);
        chk(tx_valid, 0, "R10 write while busy dropped");
        @(posedge clk); #1 tx_taken = 1;
        @(posedge clk); #1 tx_taken = 0;
        rd(8'h14, 32'h20, "R9 tx_taken sets holding empty");
        @(posedge clk); #1 tx_done = 1;
        @(posedge clk); #1 tx_done = 0;
        rd(8'h14, 32'h60, "R9 tx_done sets transmitter empty");

        // R11 / R12 transmit-empty interrupt
        wr(8'h04, 32'h2);
        @(negedge clk);
        chk(irq, 1, "R12 irq with holding empty enabled");
        rd(8'h08, 32'h2, "R11 id holding empty");

        // R5 receive and priority over transmit
        wr(8'h04, 32'h3);
        rx(8'h5A, 0, 0, 0);
        rd(8'h08, 32'h4, "R11 data ready beats holding empty");
        rd(8'h14, 32'h61, "R5 data ready set");
        rd(8'h00, 32'h5A, "R5 data byte");
        rd(8'h14, 32'h60, "R5 data ready cleared");
        rd(8'h08, 32'h2, "R11 back to holding empty");

        // R6 overrun
        wr(8'h04, 32'h7);
        rx(8'h01, 0, 0, 0);
        rx(8'h02, 0, 0, 0);
        rd(8'h14, 32'h63, "R6 overrun and data ready");
        @(negedge clk);
        chk(irq, 1, "R12 irq with overrun pending");
        rd(8'h08, 32'h4, "R7 line status read cleared overrun");
        rd(8'h00, 32'h02, "R6 newest byte kept");
        rx(8'h01, 0, 0, 0);
        rx(8'h02, 0, 0, 0);
        rd(8'h08, 32'h6, "R11 line error has top priority");
        rd(8'h00, 32'h02, "R6 newest byte kept again");
        rd(8'h14, 32'h62, "R6 overrun kept after data read");
        rd(8'h14, 32'h60, "R7 error bits cleared by read");

        // R7 error flags
        rx(8'h33, 1, 1, 1);
        rd(8'h14, 32'h7D, "R7 parity framing break set");
        rd(8'h00, 32'h33, "R5 byte with errors");
        rd(8'h14, 32'h60, "R7 errors cleared");

        // R8 modem status
        wr(8'h04, 32'h8);
        modem_lvl = 4'b1010;
        @(negedge clk);
        chk(irq, 0, "R12 no modem delta yet");
        rd(8'h18, 32'hA0, "R8 live levels");
        @(posedge clk); #1 modem_delta = 4'b0101;
        @(posedge clk); #1 modem_delta = 4'b0000;
        @(negedge clk);
        chk(irq, 1, "R12 irq on modem delta");
        rd(8'h08, 32'h0, "R11 modem id");
        rd(8'h18, 32'hA5, "R8 deltas accumulated");
        rd(8'h18, 32'hA0, "R8 deltas cleared by read");
        rd(8'h08, 32'h1, "R11 idle id");
        @(negedge clk);
        chk(irq, 0, "R12 irq low when idle");

        @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule